// File: doc/BRIEF.md
# Board Control and Parity-Error Status Register

This block is the host-visible control and status logic of a network controller board. A single 16-bit control/status word drives the controller's reset, loopback-release and channel-attention lines. The same word holds the interrupt enables, the P2-bus enable and the RAM-size select. It also reports the live controller interrupt, the latched parity-error flag and the jumpered RAM base address bits. The block merges the controller interrupt and the RAM parity-error interrupt into one host interrupt request.

When the board RAM raises a parity-error strobe, the block records the first error. It keeps the error source, the failing byte lane and the full 20-bit failing address until the host acknowledges by writing one to an acknowledge bit. Registers are selected by a 2-bit address. Address 0 is the status word, 1 is parity control, 2 is the low failing address, and 3 is unused. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, all writable status bits are 0. The outputs ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k and host_irq are 0 (with ctl_irq low), and no parity error is latched.
- R2: A write to address 0 loads bit 15 (reset), bit 14 (on-air), bit 13 (attention), bit 12 (interrupt enable), bit 11 (parity interrupt enable), bit 5 (P2 enable) and bit 4 (256 KB RAM). The matching outputs and read-back bits show the new values from the following cycle.
- R3: ctl_attn and ctl_reset follow their status bits. Setting a bit and then clearing it gives a pulse that lasts from the cycle after the set write to the cycle after the clear write.
- R4: Status bits 3:0 read the base_jmp input and bit 8 reads the live ctl_irq input. Writes to bits 9, 8 and 3:0 are ignored.
- R5: host_irq is (status bit 8 AND bit 12) OR (status bit 9 AND bit 11).
- R6: A par_strobe with no error latched sets status bit 9 from the next cycle. In the same cycle, parity control (address 1) captures par_src in bit 7, par_lane in bit 6 and par_addr[19:16] in bits 3:0, and address 2 captures par_addr[15:0].
- R7: While an error is latched, further strobes change neither the flag nor any captured field.
- R8: Writing address 1 with bit 8 = 1 clears the flag from the next cycle, and writing it with bit 8 = 0 does not. Captured fields stay readable after the clear. Writes never change the captured fields, and address 1 bit 8 reads 0.
- R9: A strobe in the same cycle as an acknowledge captures the new error, and the flag stays set.
- R10: Address 3 reads 0 and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| ctl_irq | input | 1 | Controller interrupt request |
| par_strobe | input | 1 | RAM parity-error strobe |
| par_addr | input | 20 | Failing RAM address |
| par_lane | input | 1 | Failing byte lane |
| par_src | input | 1 | Error source |
| base_jmp | input | 4 | Jumpered RAM base address bits 19:16 |
| ctl_reset | output | 1 | Controller reset |
| ctl_onair | output | 1 | Loopback release |
| ctl_attn | output | 1 | Channel attention |
| p2_en | output | 1 | P2 bus enable |
| ram_256k | output | 1 | 256 KB RAM device select |
| host_irq | output | 1 | Merged host interrupt request |

## Verification
Writes and parity strobes pass through one register stage. Their effect on the outputs and on read data is due one cycle after the edge that took them. Read data, the live interrupt bit, the jumper bits and host_irq have no register in their path and respond to inputs within the same cycle. The bench drives every input on the falling edge and samples after the next rising edge, or a short delay after changing a combinational input. Each check therefore lands in the first cycle where the result must appear.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int DATA_W = 16,
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               ctl_irq,
  input  logic               par_strobe,
  input  logic [PADDR_W-1:0] par_addr,
  input  logic               par_lane,
  input  logic               par_src,
  input  logic [3:0]         base_jmp,
  output logic               ctl_reset,
  output logic               ctl_onair,
  output logic               ctl_attn,
  output logic               p2_en,
  output logic               ram_256k,
  output logic               host_irq
);
  localparam int LO_W = PADDR_W - 4;

  logic irq_en, perr_en, perr_q, cap_src, cap_lane;
  logic [3:0]      cap_hi;
  logic [LO_W-1:0] cap_lo;
  logic wr_stat, ack, capture;

  assign wr_stat = bus_wr && (bus_addr == 2'd0);
  assign ack     = bus_wr && (bus_addr == 2'd1) && bus_wdata[8];
  assign capture = par_strobe && (!perr_q || ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_reset <= 1'b0;
      ctl_onair <= 1'b0;
      ctl_attn  <= 1'b0;
      irq_en    <= 1'b0;
      perr_en   <= 1'b0;
      p2_en     <= 1'b0;
      ram_256k  <= 1'b0;
    end else if (wr_stat) begin
      ctl_reset <= bus_wdata[15];
      ctl_onair <= bus_wdata[14];
      ctl_attn  <= bus_wdata[13];
      irq_en    <= bus_wdata[12];
      perr_en   <= bus_wdata[11];
      p2_en     <= bus_wdata[5];
      ram_256k  <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_q   <= 1'b0;
      cap_src  <= 1'b0;
      cap_lane <= 1'b0;
      cap_hi   <= '0;
      cap_lo   <= '0;
    end else begin
      perr_q <= capture || (perr_q && !ack);
      if (capture) begin
        cap_src  <= par_src;
        cap_lane <= par_lane;
        cap_hi   <= par_addr[PADDR_W-1 -: 4];
        cap_lo   <= par_addr[LO_W-1:0];
      end
    end
  end

  assign host_irq = (ctl_irq && irq_en) || (perr_q && perr_en);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[15] = ctl_reset;
        bus_rdata[14] = ctl_onair;
        bus_rdata[13] = ctl_attn;
        bus_rdata[12] = irq_en;
        bus_rdata[11] = perr_en;
        bus_rdata[9]  = perr_q;
        bus_rdata[8]  = ctl_irq;
        bus_rdata[5]  = p2_en;
        bus_rdata[4]  = ram_256k;
        bus_rdata[3:0] = base_jmp;
      end
      2'd1: begin
        bus_rdata[7]   = cap_src;
        bus_rdata[6]   = cap_lane;
        bus_rdata[3:0] = cap_hi;
      end
      2'd2: bus_rdata[LO_W-1:0] = cap_lo;
      default: bus_rdata = '0;
    endcase
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (ctl_reset == $past(bus_wdata[15])) && (ctl_attn == $past(bus_wdata[13]))
              && (p2_en == $past(bus_wdata[5])));  // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable({ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k}));  // R3
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_q && !par_strobe |=> !perr_q);  // R6
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q && !ack |=> perr_q && $stable({cap_src, cap_lane, cap_hi, cap_lo}));  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !par_strobe |=> !perr_q);  // R8
  AST_ACK_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && par_strobe |=> perr_q && (cap_lo == $past(par_addr[LO_W-1:0])));  // R9
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_irq && !perr_q |-> !host_irq);  // R5
endmodule

// File: tb/board_ctl_regs_tb.sv
`timescale 1ns/1ps
module board_ctl_regs_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic ctl_irq = 0, par_strobe = 0, par_lane = 0, par_src = 0;
  logic [19:0] par_addr = 0;
  logic [3:0] base_jmp = 4'hA;
  logic ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k, host_irq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  board_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_irq(ctl_irq),
    .par_strobe(par_strobe), .par_addr(par_addr), .par_lane(par_lane),
    .par_src(par_src), .base_jmp(base_jmp), .ctl_reset(ctl_reset),
    .ctl_onair(ctl_onair), .ctl_attn(ctl_attn), .p2_en(p2_en),
    .ram_256k(ram_256k), .host_irq(host_irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycle(input logic wr, input logic [1:0] a, input logic [15:0] d,
                       input logic stb, input logic [19:0] pa, input logic ln, input logic sr);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    par_strobe = stb; par_addr = pa; par_lane = ln; par_src = sr;
    @(negedge clk);
    bus_wr = 0; par_strobe = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cycle(1, a, d, 0, 20'h0, 0, 0);
  endtask

  task automatic strobe(input logic [19:0] pa, input logic ln, input logic sr);
    cycle(0, 2'd0, 16'h0, 1, pa, ln, sr);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 status", d, 16'h000A);
    chk("R1 outputs", {10'b0, ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k, host_irq}, 16'h0);
    rd(2'd1, d); chk("R1 pctl", d, 16'h0);
  endtask

  task automatic t_ctrl_write();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R2/R4 all set readback", d, 16'hF83A);
    chk("R2 outputs", {11'b0, ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k}, 16'h001F);
    wr(2'd0, 16'h0030);
    rd(2'd0, d); chk("R2 partial", d, 16'h003A);
    chk("R2 outputs partial", {11'b0, ctl_reset, ctl_onair, ctl_attn, p2_en, ram_256k}, 16'h0003);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_attn_reset();
    wr(2'd0, 16'h2000); chk("R3 attn high", {15'b0, ctl_attn}, 16'h1);
    wr(2'd0, 16'h0000); chk("R3 attn low", {15'b0, ctl_attn}, 16'h0);
    wr(2'd0, 16'h8000); chk("R3 reset high", {15'b0, ctl_reset}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R3 reset held", {15'b0, ctl_reset}, 16'h1);
    wr(2'd0, 16'h0000); chk("R3 reset low", {15'b0, ctl_reset}, 16'h0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    base_jmp = 4'h5;
    ctl_irq = 1;
    rd(2'd0, d); chk("R4 live irq and jumper", d, 16'h0105);
    chk("R5 irq masked", {15'b0, host_irq}, 16'h0);
    wr(2'd0, 16'h1000); #1 chk("R5 irq enabled", {15'b0, host_irq}, 16'h1);
    ctl_irq = 0; #1 chk("R5 irq dropped", {15'b0, host_irq}, 16'h0);
    base_jmp = 4'hA;
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_parity();
    logic [15:0] d;
    strobe(20'h51234, 1, 0);
    rd(2'd0, d); chk("R6 flag", d, 16'h020A);
    rd(2'd1, d); chk("R6 pctl", d, 16'h0045);
    rd(2'd2, d); chk("R6 low addr", d, 16'h1234);
    #1 chk("R5 perr masked", {15'b0, host_irq}, 16'h0);
    wr(2'd0, 16'h0800); #1 chk("R5 perr irq", {15'b0, host_irq}, 16'h1);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    strobe(20'hABCDE, 0, 1);
    rd(2'd1, d); chk("R7 pctl kept", d, 16'h0045);
    rd(2'd2, d); chk("R7 low kept", d, 16'h1234);
  endtask

  task automatic t_ack();
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    rd(2'd0, d); chk("R8 no-ack keeps flag", d & 16'h0200, 16'h0200);
    wr(2'd1, 16'h00FF);
    rd(2'd1, d); chk("R8 fields write ignored", d, 16'h0045);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk("R8 low write ignored", d, 16'h1234);
    wr(2'd1, 16'h0100);
    rd(2'd0, d); chk("R8 ack clears", d & 16'h0200, 16'h0000);
    #1 chk("R8 irq gone", {15'b0, host_irq}, 16'h0);
    rd(2'd1, d); chk("R8 fields retained", d, 16'h0045);
  endtask

  task automatic t_both();
    logic [15:0] d;
    strobe(20'h30001, 0, 1);
    rd(2'd1, d); chk("R6 second capture", d, 16'h0083);
    cycle(1, 2'd1, 16'h0100, 1, 20'hC4321, 1, 1);
    rd(2'd0, d); chk("R9 flag stays", d & 16'h0200, 16'h0200);
    rd(2'd1, d); chk("R9 pctl new", d, 16'h00CC);
    rd(2'd2, d); chk("R9 low new", d, 16'h4321);
    wr(2'd1, 16'h0100);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_unused();
    logic [15:0] d;
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk("R10 reads zero", d, 16'h0);
    rd(2'd0, d); chk("R10 status untouched", d, 16'h000A);
    rd(2'd1, d); chk("R10 pctl untouched", d, 16'h00CC);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctrl_write();
        t_attn_reset();
        t_irq();
        t_parity();
        t_hold();
        t_ack();
        t_both();
        t_unused();
      end
      begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule